// File: doc/BRIEF.md
# String load register-fill sequencer

This block executes a load-string-word-immediate style operation on behalf of a processor pipeline. Once started, it fetches a run of bytes from memory one at a time, gathers them into 32-bit words with the first byte in the most significant position, and writes each word into consecutive registers of a 32-entry register file through a single write port. Instruction decode has already produced the inputs: the first destination register index, the base register index, a 5-bit byte count field, the base register's contents, and the current endianness mode.

The destination index advances by one after each word and wraps from the top register back to register 0. Filling stops early, before any memory access for that word, when the next destination would be the base register. In little-endian mode the operation is refused with a one-cycle alignment exception. A successful or early-stopped run ends with a one-cycle done pulse.

Top module: `strload_seq`

## Requirements
- R1: A count field of 0 means 32 bytes. Any count field from 1 to 31 is the byte count itself.
- R2: Within each 32-bit word, the first byte fetched goes to bits 31:24, the second to bits 23:16, the third to bits 15:8 and the fourth to bits 7:0.
- R3: When the byte count is not a multiple of four, the last word holds its bytes left-justified and its remaining low-order bytes are zero (bytes 01,02,03 give 0x01020300).
- R4: A run that is not stopped early performs exactly ceil(count/4) register writes, and no other register changes.
- R5: The destination index increases by one after every word and wraps from 31 to 0.
- R6: When the base register index is nonzero and the next destination index equals it, the run ends with done, and neither that register nor any later one is written or fetched for.
- R7: With `little_endian` high at start, `align_exc` pulses, and there is no register write and no memory request.
- R8: Each write drives the word on `rf_wdata[31:0]` and zero on `rf_wdata[63:32]`.
- R9: The first byte address is `base_addr`, or zero when `base_idx` is 0. Each later byte address is one higher than the previous one.
- R10: At most one memory request is outstanding: `mem_req` pulses for one cycle and is not raised again until `mem_rvalid` has returned. A `start` while a run is in progress is ignored.
- R11: `done` and `align_exc` are single-cycle pulses, never high together. `done` comes after the last write of the run.
- R12: After reset, `mem_req`, `rf_we`, `done` and `align_exc` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| dst_idx | input | 5 | First destination register index |
| base_idx | input | 5 | Base register index; 0 selects address zero |
| cnt_field | input | 5 | Byte count field, 0 means 32 |
| base_addr | input | 32 | Contents of the base register |
| little_endian | input | 1 | Current endianness mode; high forces the exception |
| mem_req | output | 1 | One-cycle byte read request |
| mem_addr | output | 32 | Byte address of the request |
| mem_rvalid | input | 1 | Read data valid, answers the outstanding request |
| mem_rdata | input | 8 | Read data byte |
| rf_we | output | 1 | Register file write enable |
| rf_idx | output | 5 | Register file write index |
| rf_wdata | output | 64 | Register file write data |
| done | output | 1 | Operation finished pulse |
| align_exc | output | 1 | Alignment exception pulse |

## Verification
On every cycle, the assertions check four things. No second request is issued while one is outstanding. The base register is never a write target. The number of writes never exceeds ceil(count/4). The two end pulses last one cycle, never overlap, and a refused run has made no writes. Only the bench scenarios can show the rest: the byte order and zero padding inside each word, the 32-byte meaning of a zero count field, wrap-around from register 31 to 0, the byte address sequence, that the register after the last one keeps its value, and that a start during a run leaves the result unchanged.

// File: rtl/strload_pkg.sv
package strload_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WORD,
      ST_REQ,
      ST_WAIT,
      ST_WRITE,
      ST_FIN,
      ST_EXC
   } sl_state_e;

endpackage

// File: rtl/strload_count.sv
module strload_count #(
   parameter int CNT_W    = 5,
   parameter int WB       = 4,
   localparam int NB_W    = CNT_W + 1
) (
   input  logic [CNT_W-1:0] cnt_field,
   output logic [NB_W-1:0]  nbytes,
   output logic [NB_W-1:0]  nwords
);
   localparam int POS_W = $clog2(WB);
   localparam int SUM_W = NB_W + POS_W + 1;

   if (CNT_W < 1) begin : g_bad_cnt
      $error("strload_count: CNT_W must be at least 1");
   end
   if ((1 << POS_W) != WB) begin : g_bad_wb
      $error("strload_count: WB must be a power of two");
   end

   logic [SUM_W-1:0] sum;

   always_comb begin
      if (cnt_field == '0) nbytes = {1'b1, {CNT_W{1'b0}}};
      else                 nbytes = {1'b0, cnt_field};
      sum    = SUM_W'(nbytes) + SUM_W'(WB - 1);
      nwords = NB_W'(sum >> POS_W);
   end

endmodule

// File: rtl/strload_pack.sv
module strload_pack #(
   parameter int WORD_W = 32,
   localparam int WB    = WORD_W / 8,
   localparam int POS_W = $clog2(WB)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic [POS_W-1:0]  pos,
   input  logic [7:0]        byte_in,
   output logic [WORD_W-1:0] word
);
   if ((WORD_W % 8) != 0 || WB < 2) begin : g_bad_word
      $error("strload_pack: WORD_W must be a multiple of 8, at least 16");
   end

   for (genvar j = 0; j < WB; j++) begin : g_lane
      localparam logic [POS_W-1:0] LANE_POS = POS_W'(WB - 1 - j);
      logic [7:0] lane_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          lane_q <= '0;
         else if (clr)                        lane_q <= '0;
         else if (load && pos == LANE_POS)    lane_q <= byte_in;
      end

      assign word[8*j +: 8] = lane_q;
   end

endmodule

// File: rtl/strload_ctrl.sv
module strload_ctrl
   import strload_pkg::*;
#(
   parameter int REG_IDX_W = 5,
   parameter int CNT_W     = 5,
   parameter int ADDR_W    = 32,
   parameter int WORD_W    = 32,
   localparam int NB_W     = CNT_W + 1,
   localparam int WB       = WORD_W / 8,
   localparam int POS_W    = $clog2(WB)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [REG_IDX_W-1:0] dst_idx,
   input  logic [REG_IDX_W-1:0] base_idx,
   input  logic [ADDR_W-1:0]    base_addr,
   input  logic                 little_endian,
   input  logic [NB_W-1:0]      nbytes_in,
   input  logic [NB_W-1:0]      nwords_in,
   output logic                 mem_req,
   output logic [ADDR_W-1:0]    mem_addr,
   input  logic                 mem_rvalid,
   output logic                 pk_clr,
   output logic                 pk_load,
   output logic [POS_W-1:0]     pk_pos,
   output logic                 rf_we,
   output logic [REG_IDX_W-1:0] rf_idx,
   output logic                 done,
   output logic                 align_exc
);
   sl_state_e             state_q;
   logic [REG_IDX_W-1:0]  idx_q;
   logic [REG_IDX_W-1:0]  base_q;
   logic [ADDR_W-1:0]     addr_q;
   logic [NB_W-1:0]       rem_q;
   logic [NB_W-1:0]       words_q;
   logic [NB_W-1:0]       wr_cnt_q;
   logic [POS_W-1:0]      pos_q;

   logic guard_hit;
   logic last_byte;

   assign guard_hit = (base_q != '0) && (idx_q == base_q);
   assign last_byte = (pos_q == POS_W'(WB - 1)) || (rem_q == NB_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         idx_q    <= '0;
         base_q   <= '0;
         addr_q   <= '0;
         rem_q    <= '0;
         words_q  <= '0;
         wr_cnt_q <= '0;
         pos_q    <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  idx_q    <= dst_idx;
                  base_q   <= base_idx;
                  addr_q   <= (base_idx == '0) ? '0 : base_addr;
                  rem_q    <= nbytes_in;
                  words_q  <= nwords_in;
                  wr_cnt_q <= '0;
                  state_q  <= little_endian ? ST_EXC : ST_WORD;
               end
            end
            ST_WORD: begin
               pos_q <= '0;
               if (rem_q == '0 || guard_hit) state_q <= ST_FIN;
               else                          state_q <= ST_REQ;
            end
            ST_REQ: state_q <= ST_WAIT;
            ST_WAIT: begin
               if (mem_rvalid) begin
                  addr_q  <= addr_q + ADDR_W'(1);
                  rem_q   <= rem_q - NB_W'(1);
                  pos_q   <= pos_q + POS_W'(1);
                  state_q <= last_byte ? ST_WRITE : ST_REQ;
               end
            end
            ST_WRITE: begin
               idx_q    <= idx_q + REG_IDX_W'(1);
               wr_cnt_q <= wr_cnt_q + NB_W'(1);
               state_q  <= ST_WORD;
            end
            ST_FIN:  state_q <= ST_IDLE;
            ST_EXC:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = (state_q == ST_REQ);
      mem_addr  = addr_q;
      pk_clr    = (state_q == ST_WORD);
      pk_load   = (state_q == ST_WAIT) && mem_rvalid;
      pk_pos    = pos_q;
      rf_we     = (state_q == ST_WRITE);
      rf_idx    = idx_q;
      done      = (state_q == ST_FIN);
      align_exc = (state_q == ST_EXC);
   end

   // outstanding-request tracker used only by the checks below
   logic out_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          out_q <= 1'b0;
      else if (mem_req)    out_q <= 1'b1;
      else if (mem_rvalid) out_q <= 1'b0;
   end

   assert_single_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !out_q);

   assert_skip_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> !((base_q != '0) && (rf_idx == base_q)));

   assert_write_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> (wr_cnt_q < words_q));

   assert_end_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done || align_exc) |=> !(done || align_exc));

   assert_end_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && align_exc));

   assert_exc_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
      align_exc |-> (wr_cnt_q == '0));

endmodule

// File: rtl/strload_seq.sv
module strload_seq #(
   parameter int REG_IDX_W = 5,
   parameter int CNT_W     = 5,
   parameter int ADDR_W    = 32,
   parameter int WORD_W    = 32,
   parameter int XLEN      = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [REG_IDX_W-1:0] dst_idx,
   input  logic [REG_IDX_W-1:0] base_idx,
   input  logic [CNT_W-1:0]     cnt_field,
   input  logic [ADDR_W-1:0]    base_addr,
   input  logic                 little_endian,
   output logic                 mem_req,
   output logic [ADDR_W-1:0]    mem_addr,
   input  logic                 mem_rvalid,
   input  logic [7:0]           mem_rdata,
   output logic                 rf_we,
   output logic [REG_IDX_W-1:0] rf_idx,
   output logic [XLEN-1:0]      rf_wdata,
   output logic                 done,
   output logic                 align_exc
);
   localparam int NB_W  = CNT_W + 1;
   localparam int WB    = WORD_W / 8;
   localparam int POS_W = $clog2(WB);

   if (XLEN < WORD_W) begin : g_bad_xlen
      $error("strload_seq: XLEN must not be below WORD_W");
   end

   logic [NB_W-1:0]   nbytes;
   logic [NB_W-1:0]   nwords;
   logic              pk_clr;
   logic              pk_load;
   logic [POS_W-1:0]  pk_pos;
   logic [WORD_W-1:0] word;

   strload_count #(.CNT_W(CNT_W), .WB(WB)) u_count (
      .cnt_field (cnt_field),
      .nbytes    (nbytes),
      .nwords    (nwords)
   );

   strload_pack #(.WORD_W(WORD_W)) u_pack (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (pk_clr),
      .load    (pk_load),
      .pos     (pk_pos),
      .byte_in (mem_rdata),
      .word    (word)
   );

   strload_ctrl #(
      .REG_IDX_W (REG_IDX_W),
      .CNT_W     (CNT_W),
      .ADDR_W    (ADDR_W),
      .WORD_W    (WORD_W)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (start),
      .dst_idx       (dst_idx),
      .base_idx      (base_idx),
      .base_addr     (base_addr),
      .little_endian (little_endian),
      .nbytes_in     (nbytes),
      .nwords_in     (nwords),
      .mem_req       (mem_req),
      .mem_addr      (mem_addr),
      .mem_rvalid    (mem_rvalid),
      .pk_clr        (pk_clr),
      .pk_load       (pk_load),
      .pk_pos        (pk_pos),
      .rf_we         (rf_we),
      .rf_idx        (rf_idx),
      .done          (done),
      .align_exc     (align_exc)
   );

   if (XLEN > WORD_W) begin : g_zext
      assign rf_wdata = {{(XLEN - WORD_W){1'b0}}, word};
   end else begin : g_same
      assign rf_wdata = word;
   end

endmodule

// File: tb/test_strload_seq.sv
module test_strload_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [4:0]  dst_idx = '0;
   logic [4:0]  base_idx = '0;
   logic [4:0]  cnt_field = '0;
   logic [31:0] base_addr = '0;
   logic        little_endian = 1'b0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [7:0]  mem_rdata = '0;
   logic        rf_we;
   logic [4:0]  rf_idx;
   logic [63:0] rf_wdata;
   logic        done;
   logic        align_exc;

   strload_seq i_strload_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .dst_idx(dst_idx),
      .base_idx(base_idx), .cnt_field(cnt_field), .base_addr(base_addr),
      .little_endian(little_endian), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rf_we(rf_we),
      .rf_idx(rf_idx), .rf_wdata(rf_wdata), .done(done), .align_exc(align_exc)
   );

   always #10 clk = ~clk;   // 50 MHz

   int          vectors = 0;
   int          miscompares = 0;
   bit          finished = 0;
   logic [36:0] exp_q[$];          // {idx, word}
   logic [31:0] shadow[32];
   logic [31:0] exp_addr = '0;
   bit          mem_allowed = 0;
   int          mem_lat = 0;
   bit          pend = 0;
   int          pcnt = 0;
   logic [31:0] paddr = '0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // memory model: byte at address a is a[7:0]+1
   always @(negedge clk) begin
      if (mem_rvalid) mem_rvalid = 1'b0;
      if (pend) begin
         if (pcnt == 0) begin
            mem_rvalid = 1'b1;
            mem_rdata  = paddr[7:0] + 8'd1;
            pend       = 0;
         end else pcnt--;
      end
      if (rst_n && mem_req) begin
         check(mem_allowed, "R7", "memory request", 64'(mem_req), 64'd0);
         check(mem_addr == exp_addr, "R9", "byte address", 64'(mem_addr), 64'(exp_addr));
         check(!pend, "R10", "second request", 64'(pend), 64'd0);
         exp_addr = exp_addr + 32'd1;
         pend  = 1;
         pcnt  = mem_lat;
         paddr = mem_addr;
      end
   end

   // monitor: scoreboard pop on each register write
   always @(negedge clk) begin
      if (rst_n && rf_we) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R4", "unexpected write idx", 64'(rf_idx), 64'd0);
         end else begin
            logic [36:0] e;
            e = exp_q.pop_front();
            check(rf_idx == e[36:32], "R5", "write index", 64'(rf_idx), 64'(e[36:32]));
            check(rf_wdata[31:0] == e[31:0], "R2", "write word", rf_wdata, 64'(e[31:0]));
            check(rf_wdata[63:32] == 32'd0, "R8", "upper half", rf_wdata, 64'(e[31:0]));
         end
         shadow[rf_idx] = rf_wdata[31:0];
      end
   end

   task automatic run_op(input logic [4:0] dst, input logic [4:0] base,
                         input logic [4:0] field, input logic [31:0] baddr,
                         input bit le, input int lat, input bit poke_busy,
                         input string req);
      int cnt;
      int b;
      logic [4:0] idx;
      logic [31:0] a0;
      bit got;
      cnt = (field == 0) ? 32 : int'(field);
      a0  = (base == 0) ? 32'd0 : baddr;
      if (!le) begin
         idx = dst;
         b = 0;
         while (b < cnt) begin
            logic [31:0] w;
            if (base != 0 && idx == base) break;
            w = '0;
            for (int k = 0; k < 4; k++) begin
               if (b < cnt) begin
                  logic [7:0] by;
                  by = 8'(a0 + 32'(b)) + 8'd1;
                  w[31-8*k -: 8] = by;
                  b++;
               end
            end
            exp_q.push_back({idx, w});
            idx = idx + 5'd1;
         end
      end
      exp_addr    = a0;
      mem_allowed = !le;
      mem_lat     = lat;
      @(negedge clk);
      dst_idx = dst; base_idx = base; cnt_field = field;
      base_addr = baddr; little_endian = le; start = 1'b1;
      @(negedge clk);
      start = 1'b0; little_endian = 1'b0;
      if (poke_busy) begin
         repeat (3) @(negedge clk);
         dst_idx = 5'd2; cnt_field = 5'd1; little_endian = 1'b1; start = 1'b1;
         @(negedge clk);
         start = 1'b0; little_endian = 1'b0;
      end
      got = 0;
      for (int n = 0; n < 3000; n++) begin
         if (done || align_exc) begin got = 1; break; end
         @(negedge clk);
      end
      check(got, req, "operation end seen", 64'(got), 64'd1);
      check(align_exc == le, req, "exception vs done", 64'(align_exc), 64'(le));
      check(done == !le, "R11", "done level", 64'(done), 64'(!le));
      check(exp_q.size() == 0, "R4", "writes left over", 64'(exp_q.size()), 64'd0);
      exp_q.delete();
      @(negedge clk);
      check(!done && !align_exc, "R11", "end pulse width", 64'({done, align_exc}), 64'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         miscompares++;
         $display("FAIL watchdog: actual expired expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 32; i++) shadow[i] = 32'hA5A50000 + 32'(i);
      repeat (3) @(negedge clk);
      check({mem_req, rf_we, done, align_exc} == 4'b0, "R12", "outputs in reset",
            64'({mem_req, rf_we, done, align_exc}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check({mem_req, rf_we, done, align_exc} == 4'b0, "R12", "outputs after reset",
            64'({mem_req, rf_we, done, align_exc}), 64'd0);

      // R3: three bytes, one partial word, next register kept
      run_op(5'd11, 5'd0, 5'd3, 32'h0, 1'b0, 0, 1'b0, "R3");
      check(shadow[11] == 32'h01020300, "R3", "partial word", 64'(shadow[11]), 64'h01020300);
      check(shadow[12] == 32'hA5A5000C, "R4", "r12 kept", 64'(shadow[12]), 64'hA5A5000C);

      // R1: field 0 -> 32 bytes, eight registers, r19 kept
      run_op(5'd11, 5'd0, 5'd0, 32'h0, 1'b0, 1, 1'b0, "R1");
      check(shadow[18] == 32'h1D1E1F20, "R1", "eighth word", 64'(shadow[18]), 64'h1D1E1F20);
      check(shadow[19] == 32'hA5A50013, "R4", "r19 kept", 64'(shadow[19]), 64'hA5A50013);

      // R5: wrap from 31 to 0
      run_op(5'd31, 5'd0, 5'd8, 32'h0, 1'b0, 2, 1'b0, "R5");
      check(shadow[0] == 32'h05060708, "R5", "wrapped word", 64'(shadow[0]), 64'h05060708);
      check(shadow[1] == 32'hA5A50001, "R4", "r1 kept", 64'(shadow[1]), 64'hA5A50001);

      // R6: stop at the base register after wrap
      run_op(5'd31, 5'd1, 5'd16, 32'h100, 1'b0, 0, 1'b0, "R6");
      check(shadow[1] == 32'hA5A50001, "R6", "base reg kept", 64'(shadow[1]), 64'hA5A50001);
      check(shadow[2] == 32'hA5A50002, "R6", "later reg kept", 64'(shadow[2]), 64'hA5A50002);

      // R6: destination equals base at once, no writes
      run_op(5'd5, 5'd5, 5'd4, 32'h40, 1'b0, 0, 1'b0, "R6");
      check(shadow[5] == 32'hA5A50005, "R6", "first reg is base", 64'(shadow[5]), 64'hA5A50005);

      // R7: little-endian refused
      run_op(5'd20, 5'd0, 5'd4, 32'h0, 1'b1, 0, 1'b0, "R7");
      check(shadow[20] == 32'hA5A50014, "R7", "no write", 64'(shadow[20]), 64'hA5A50014);

      // R9: nonzero base address, seven bytes
      run_op(5'd8, 5'd3, 5'd7, 32'h2F0, 1'b0, 1, 1'b0, "R9");
      check(shadow[9] == 32'hF5F6F700, "R9", "second word", 64'(shadow[9]), 64'hF5F6F700);

      // R9: base index 0 ignores base_addr
      run_op(5'd24, 5'd0, 5'd5, 32'h777, 1'b0, 0, 1'b0, "R9");
      check(shadow[24] == 32'h01020304, "R9", "address zero", 64'(shadow[24]), 64'h01020304);

      // R10: start during a run is ignored
      run_op(5'd12, 5'd0, 5'd10, 32'h0, 1'b0, 2, 1'b1, "R10");
      check(shadow[14] == 32'h090A0000, "R10", "last word", 64'(shadow[14]), 64'h090A0000);
      check(shadow[2] == 32'hA5A50002, "R10", "poked reg kept", 64'(shadow[2]), 64'hA5A50002);

      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule